// File: doc/BRIEF.md
# Deferred Parallel Writeback Queue

This block holds back every register and PC write issued by the instructions of one long instruction word packet. Nothing reaches architectural state while the packet executes, so each instruction in the packet reads the state from before the packet. When the packet ends, a commit request drains the queue one entry per cycle. Register entries go to a register-file write port. PC entries choose the next PC, and a link-register write can follow the drain.

Each enqueued entry carries a kind, a target index, a value, the address of the instruction that issued it, and a force flag. An imprecise-exception snapshot is taken when the commit starts. It suppresses entries from the faulting instruction unless its exception kind or the entry's force flag permits the write. Only the first PC write that survives the filter takes effect.

The controller is a three-state machine. ST_IDLE accepts packet-start, enqueue and commit requests. On commit it moves to ST_DRAIN, or straight to ST_FINISH when the queue is empty. ST_DRAIN commits one entry per cycle and moves to ST_FINISH after the entry at the fill count captured at commit start. ST_FINISH publishes the final PC and the optional link write, empties the queue, and returns to ST_IDLE.

Top module: `wbq_top`

## Requirements
- R1: After reset, busy, overflow, rf_we, pc_we and lr_we are 0 and pc_vis is 0.
- R2: A pkt_start pulse in idle empties the queue, clears overflow, and from the next cycle shows the cur_pc it sampled on pkt_base_pc.
- R3: An enqueue while DEPTH entries are held is dropped and sets overflow, which stays set until the next accepted pkt_start.
- R4: Encodings: enq_kind 0 is a register write, 1 is a PC write, 2 is a function-PC write, and 3 is treated as a register write. After a commit_start, busy is high from the next cycle until the finish cycle, inclusive. Entry i (enqueue order, i from 0) is handled in cycle i+1 after commit_start. A kept register entry drives rf_we with its index and value in that cycle.
- R5: In the cycle entry i is handled, pc_vis equals that entry's issuing address.
- R6: Only the first kept entry of kind 1 or 2 sets the new PC from its value. Later PC entries are discarded, and no PC entry ever drives rf_we.
- R7: If no PC entry is kept, the new PC is the cur_pc sampled with commit_start.
- R8: The finish cycle (cycle 1 after commit_start for an empty queue, otherwise the cycle after the last entry) pulses pc_we for one cycle with pc_vis equal to the new PC. pc_vis then holds that value, and the queue is empty.
- R9: The exception filter applies only to entries whose issuing address equals exc_iaddr while exc_pending is set. All other entries commit normally.
- R10: For a floating-point exception (exc_is_fp=1), the faulting instruction's entries are kept only if exc_mask has no bit set outside bit0 (inexact), bit1 (underflow) and bit2 (overflow).
- R11: For a non-floating-point exception, the faulting instruction's entries are kept only if their force flag is set.
- R12: If link_req was set with commit_start, lr_we pulses in the finish cycle with lr_data equal to the cur_pc sampled at commit start. Otherwise lr_we stays 0.
- R13: While busy, enq_valid, pkt_start and commit_start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | Start of packet: clear queue, capture PC |
| cur_pc | input | AW | Current PC, sampled by pkt_start and commit_start |
| enq_valid | input | 1 | Enqueue request |
| enq_kind | input | 2 | Entry kind (0 reg, 1 PC, 2 function-PC, 3 reg) |
| enq_idx | input | IW | Register index |
| enq_data | input | DW | Value to write |
| enq_iaddr | input | AW | Issuing instruction address |
| enq_force | input | 1 | Force flag |
| commit_start | input | 1 | Begin draining the queue |
| link_req | input | 1 | Write link register after drain |
| exc_pending | input | 1 | Imprecise exception pending |
| exc_iaddr | input | AW | Faulting instruction address |
| exc_is_fp | input | 1 | Exception is floating-point |
| exc_mask | input | MW | Floating-point status mask |
| busy | output | 1 | Commit in progress |
| overflow | output | 1 | Sticky enqueue-overflow error |
| pkt_base_pc | output | AW | PC captured at packet start |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | IW | Register-file write index |
| rf_data | output | DW | Register-file write data |
| pc_vis | output | AW | Visible PC |
| pc_we | output | 1 | Final PC update strobe |
| lr_we | output | 1 | Link-register write strobe |
| lr_data | output | AW | Link-register write value |

## Verification
The bench builds the queue with DEPTH=8, AW=16, DW=16 and IW=5. The shallow depth lets random packets of up to ten entries both reach the full boundary and run past it, which exercises the overflow drop and the sticky error on many packets. Issuing addresses are drawn from three values, so exception snapshots often match some entries of a packet and not others. Random PC-kind mixes often place several branches in one packet, which tests that only the first surviving one is taken.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

    typedef enum logic [1:0] {
        WK_REG  = 2'd0,
        WK_PC   = 2'd1,
        WK_FNPC = 2'd2,
        WK_RSV  = 2'd3
    } wk_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_FINISH = 2'd2
    } st_e;

    function automatic logic is_pc_kind(input logic [1:0] k);
        return (wk_e'(k) == WK_PC) || (wk_e'(k) == WK_FNPC);
    endfunction

endpackage

// File: rtl/wbq_store.sv
module wbq_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IW    = 6,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          clr_ovf,
    input  logic          wr_req,
    input  logic [1:0]    wr_kind,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] wr_iaddr,
    input  logic          wr_force,
    input  logic          busy,
    input  logic [PW-1:0] rd_addr,
    output logic [1:0]    rd_kind,
    output logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_iaddr,
    output logic          rd_force,
    output logic [CW-1:0] count,
    output logic          ovf
);

    logic [1:0]    m_kind  [DEPTH];
    logic [IW-1:0] m_idx   [DEPTH];
    logic [DW-1:0] m_data  [DEPTH];
    logic [AW-1:0] m_iaddr [DEPTH];
    logic          m_force [DEPTH];

    logic full;
    logic do_wr;

    assign full  = (count == CW'(DEPTH));
    assign do_wr = wr_req && !full && !clr;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            m_kind[count[PW-1:0]]  <= wr_kind;
            m_idx[count[PW-1:0]]   <= wr_idx;
            m_data[count[PW-1:0]]  <= wr_data;
            m_iaddr[count[PW-1:0]] <= wr_iaddr;
            m_force[count[PW-1:0]] <= wr_force;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (clr)
                count <= '0;
            else if (do_wr)
                count <= count + CW'(1);
            if (clr_ovf)
                ovf <= 1'b0;
            else if (wr_req && full)
                ovf <= 1'b1;
        end
    end

    assign rd_kind  = m_kind[rd_addr];
    assign rd_idx   = m_idx[rd_addr];
    assign rd_data  = m_data[rd_addr];
    assign rd_iaddr = m_iaddr[rd_addr];
    assign rd_force = m_force[rd_addr];

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

    // R13
    busy_enq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr) |=> $stable(count));

endmodule

// File: rtl/wbq_filter.sv
module wbq_filter #(
    parameter int          AW     = 32,
    parameter int          MW     = 8,
    parameter logic [MW-1:0] BENIGN = MW'(7)
) (
    input  logic          ex_pend,
    input  logic [AW-1:0] ex_iaddr,
    input  logic          ex_fp,
    input  logic [MW-1:0] ex_mask,
    input  logic [AW-1:0] ent_iaddr,
    input  logic          ent_force,
    output logic          keep
);

    logic hit;
    logic fp_ok;

    always_comb begin
        hit   = ex_pend && (ent_iaddr == ex_iaddr);
        fp_ok = ((ex_mask & ~BENIGN) == '0);
        if (!hit)
            keep = 1'b1;
        else if (ex_fp)
            keep = fp_ok;
        else
            keep = ent_force;
    end

    // R9
    filter_scope_chk: assert final (ex_pend || keep);

endmodule

// File: rtl/wbq_ctrl.sv
module wbq_ctrl
    import wbq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int MW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_start,
    input  logic          commit_start,
    input  logic          link_req,
    input  logic [AW-1:0] cur_pc,
    input  logic          exc_pending,
    input  logic [AW-1:0] exc_iaddr,
    input  logic          exc_is_fp,
    input  logic [MW-1:0] exc_mask,
    input  logic [CW-1:0] count,
    input  logic [1:0]    ent_kind,
    input  logic [DW-1:0] ent_data,
    input  logic [AW-1:0] ent_iaddr,
    input  logic          keep,
    output logic          ex_pend,
    output logic [AW-1:0] ex_iaddr,
    output logic          ex_fp,
    output logic [MW-1:0] ex_mask,
    output logic [PW-1:0] rd_addr,
    output logic          busy,
    output logic          q_clr,
    output logic          ovf_clr,
    output logic [AW-1:0] base_pc,
    output logic          rf_we,
    output logic [AW-1:0] pc_vis,
    output logic          pc_we,
    output logic          lr_we,
    output logic [AW-1:0] lr_data
);

    st_e state, nstate;

    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] limit;
    logic [AW-1:0] saved_pc;
    logic [AW-1:0] new_pc;
    logic [AW-1:0] last_pc;
    logic          br_taken;
    logic          link_f;
    logic          last_ent;
    logic          take_br;
    logic          start_ok;
    logic          pkt_ok;

    assign start_ok = (state == ST_IDLE) && commit_start;
    assign pkt_ok   = (state == ST_IDLE) && pkt_start && !commit_start;
    assign last_ent = (CW'(rd_ptr) == (limit - CW'(1)));
    assign take_br  = keep && is_pc_kind(ent_kind) && !br_taken;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (commit_start) nstate = (count == '0) ? ST_FINISH : ST_DRAIN;
            ST_DRAIN:  if (last_ent) nstate = ST_FINISH;
            ST_FINISH: nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            limit    <= '0;
            saved_pc <= '0;
            new_pc   <= '0;
            last_pc  <= '0;
            base_pc  <= '0;
            br_taken <= 1'b0;
            link_f   <= 1'b0;
            ex_pend  <= 1'b0;
            ex_iaddr <= '0;
            ex_fp    <= 1'b0;
            ex_mask  <= '0;
        end else begin
            if (pkt_ok)
                base_pc <= cur_pc;
            if (start_ok) begin
                limit    <= count;
                saved_pc <= cur_pc;
                new_pc   <= cur_pc;
                br_taken <= 1'b0;
                rd_ptr   <= '0;
                link_f   <= link_req;
                ex_pend  <= exc_pending;
                ex_iaddr <= exc_iaddr;
                ex_fp    <= exc_is_fp;
                ex_mask  <= exc_mask;
            end
            if (state == ST_DRAIN) begin
                rd_ptr <= rd_ptr + PW'(1);
                if (take_br) begin
                    br_taken <= 1'b1;
                    new_pc   <= AW'(ent_data);
                end
            end
            if (state == ST_FINISH) begin
                last_pc <= new_pc;
                link_f  <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_addr = rd_ptr;
        busy    = 1'b0;
        q_clr   = pkt_ok;
        ovf_clr = pkt_ok;
        rf_we   = 1'b0;
        pc_we   = 1'b0;
        lr_we   = 1'b0;
        lr_data = saved_pc;
        pc_vis  = last_pc;
        unique case (state)
            ST_IDLE: ;
            ST_DRAIN: begin
                busy   = 1'b1;
                pc_vis = ent_iaddr;
                rf_we  = keep && !is_pc_kind(ent_kind);
            end
            ST_FINISH: begin
                busy   = 1'b1;
                q_clr  = 1'b1;
                pc_vis = new_pc;
                pc_we  = 1'b1;
                lr_we  = link_f;
            end
            default: ;
        endcase
    end

    // R6
    first_branch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && state == ST_DRAIN) |=> $stable(new_pc));

    // R4
    drain_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (CW'(rd_ptr) < limit));

    // R8
    pc_we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (!pc_we && !busy && pc_vis == $past(pc_vis)));

    // R12
    lr_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> pc_we);

endmodule

// File: rtl/wbq_top.sv
module wbq_top
    import wbq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IW    = 6,
    parameter int MW    = 8,
    parameter logic [MW-1:0] BENIGN = MW'(7),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_start,
    input  logic [AW-1:0] cur_pc,
    input  logic          enq_valid,
    input  logic [1:0]    enq_kind,
    input  logic [IW-1:0] enq_idx,
    input  logic [DW-1:0] enq_data,
    input  logic [AW-1:0] enq_iaddr,
    input  logic          enq_force,
    input  logic          commit_start,
    input  logic          link_req,
    input  logic          exc_pending,
    input  logic [AW-1:0] exc_iaddr,
    input  logic          exc_is_fp,
    input  logic [MW-1:0] exc_mask,
    output logic          busy,
    output logic          overflow,
    output logic [AW-1:0] pkt_base_pc,
    output logic          rf_we,
    output logic [IW-1:0] rf_idx,
    output logic [DW-1:0] rf_data,
    output logic [AW-1:0] pc_vis,
    output logic          pc_we,
    output logic          lr_we,
    output logic [AW-1:0] lr_data
);

    logic          q_clr, ovf_clr, keep;
    logic [PW-1:0] rd_addr;
    logic [1:0]    ent_kind;
    logic [DW-1:0] ent_data;
    logic [AW-1:0] ent_iaddr;
    logic          ent_force;
    logic [CW-1:0] count;
    logic          ex_pend, ex_fp;
    logic [AW-1:0] ex_iaddr;
    logic [MW-1:0] ex_mask;
    logic          wr_req;

    assign wr_req = enq_valid && !busy;

    wbq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(q_clr), .clr_ovf(ovf_clr),
        .wr_req(wr_req), .wr_kind(enq_kind), .wr_idx(enq_idx),
        .wr_data(enq_data), .wr_iaddr(enq_iaddr), .wr_force(enq_force),
        .busy(busy), .rd_addr(rd_addr), .rd_kind(ent_kind), .rd_idx(rf_idx),
        .rd_data(ent_data), .rd_iaddr(ent_iaddr), .rd_force(ent_force),
        .count(count), .ovf(overflow)
    );

    wbq_filter #(.AW(AW), .MW(MW), .BENIGN(BENIGN)) u_filter (
        .ex_pend(ex_pend), .ex_iaddr(ex_iaddr), .ex_fp(ex_fp),
        .ex_mask(ex_mask), .ent_iaddr(ent_iaddr), .ent_force(ent_force),
        .keep(keep)
    );

    wbq_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MW(MW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
        .commit_start(commit_start), .link_req(link_req), .cur_pc(cur_pc),
        .exc_pending(exc_pending), .exc_iaddr(exc_iaddr),
        .exc_is_fp(exc_is_fp), .exc_mask(exc_mask), .count(count),
        .ent_kind(ent_kind), .ent_data(ent_data), .ent_iaddr(ent_iaddr),
        .keep(keep), .ex_pend(ex_pend), .ex_iaddr(ex_iaddr), .ex_fp(ex_fp),
        .ex_mask(ex_mask), .rd_addr(rd_addr), .busy(busy), .q_clr(q_clr),
        .ovf_clr(ovf_clr), .base_pc(pkt_base_pc), .rf_we(rf_we),
        .pc_vis(pc_vis), .pc_we(pc_we), .lr_we(lr_we), .lr_data(lr_data)
    );

    assign rf_data = ent_data;

    // R8
    empty_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (count == '0));

endmodule

// File: tb/sim_wbq_top.sv
module sim_wbq_top;

    localparam int DEPTH = 8;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int IW = 5;
    localparam int MW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_start = 0, enq_valid = 0, enq_force = 0, commit_start = 0;
    logic link_req = 0, exc_pending = 0, exc_is_fp = 0;
    logic [AW-1:0] cur_pc = '0, enq_iaddr = '0, exc_iaddr = '0;
    logic [1:0] enq_kind = '0;
    logic [IW-1:0] enq_idx = '0;
    logic [DW-1:0] enq_data = '0;
    logic [MW-1:0] exc_mask = '0;
    logic busy, overflow, rf_we, pc_we, lr_we;
    logic [AW-1:0] pkt_base_pc, pc_vis, lr_data;
    logic [IW-1:0] rf_idx;
    logic [DW-1:0] rf_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [1:0]    mk [16];
    logic [IW-1:0] mi [16];
    logic [DW-1:0] md [16];
    logic [AW-1:0] ma [16];
    logic          mf [16];
    int            mn = 0;
    logic [AW-1:0] last_pc_exp = '0;

    always #5 clk = ~clk;

    wbq_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW), .MW(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .cur_pc(cur_pc),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_idx(enq_idx),
        .enq_data(enq_data), .enq_iaddr(enq_iaddr), .enq_force(enq_force),
        .commit_start(commit_start), .link_req(link_req),
        .exc_pending(exc_pending), .exc_iaddr(exc_iaddr),
        .exc_is_fp(exc_is_fp), .exc_mask(exc_mask), .busy(busy),
        .overflow(overflow), .pkt_base_pc(pkt_base_pc), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_data(rf_data), .pc_vis(pc_vis), .pc_we(pc_we),
        .lr_we(lr_we), .lr_data(lr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_keep(input bit ep, input logic [AW-1:0] eia,
                                    input bit efp, input logic [MW-1:0] em,
                                    input logic [AW-1:0] ia, input bit frc);
        if (!ep || ia != eia) return 1'b1;
        if (efp) return (em & ~8'h07) == 8'h00;
        return frc;
    endfunction

    task automatic do_pkt(input logic [AW-1:0] pc);
        pkt_start = 1; cur_pc = pc;
        @(negedge clk);
        pkt_start = 0;
        mn = 0;
        chk(pkt_base_pc == pc, "R2 base pc", 32'(pkt_base_pc), 32'(pc));
        chk(overflow == 1'b0, "R2 overflow cleared", 32'(overflow), 0);
    endtask

    task automatic do_enq(input logic [1:0] k, input logic [IW-1:0] ix,
                          input logic [DW-1:0] d, input logic [AW-1:0] ia,
                          input bit frc);
        enq_valid = 1; enq_kind = k; enq_idx = ix; enq_data = d;
        enq_iaddr = ia; enq_force = frc;
        @(negedge clk);
        enq_valid = 0;
        if (mn < DEPTH) begin
            mk[mn] = k; mi[mn] = ix; md[mn] = d; ma[mn] = ia; mf[mn] = frc;
            mn++;
        end
    endtask

    task automatic do_commit(input logic [AW-1:0] cpc, input bit lnk,
                             input bit ep, input logic [AW-1:0] eia,
                             input bit efp, input logic [MW-1:0] em,
                             input bit hold_inputs);
        bit brt;
        logic [AW-1:0] npc;
        commit_start = 1; cur_pc = cpc; link_req = lnk;
        exc_pending = ep; exc_iaddr = eia; exc_is_fp = efp; exc_mask = em;
        @(negedge clk);
        commit_start = hold_inputs; link_req = 0; exc_pending = 0;
        pkt_start = hold_inputs; enq_valid = hold_inputs;
        enq_kind = 2'd1; enq_data = 16'hDEAD; enq_iaddr = 16'h0777;
        brt = 0; npc = cpc;
        for (int i = 0; i < mn; i++) begin
            bit kp, pcw, ew;
            kp = exp_keep(ep, eia, efp, em, ma[i], mf[i]);
            pcw = (mk[i] == 2'd1) || (mk[i] == 2'd2);
            ew = kp && !pcw;
            if (kp && pcw && !brt) begin brt = 1; npc = AW'(md[i]); end
            chk(busy == 1'b1, "R4 busy in drain", 32'(busy), 1);
            chk(pc_vis == ma[i], "R5 pc_vis per entry", 32'(pc_vis), 32'(ma[i]));
            chk(rf_we == ew, "R4/R6/R9/R10/R11 write enable", 32'(rf_we), 32'(ew));
            if (ew)
                chk(rf_idx == mi[i] && rf_data == md[i], "R4 write order",
                    {16'(rf_idx), rf_data}, {16'(mi[i]), md[i]});
            @(negedge clk);
        end
        chk(pc_we == 1'b1 && busy == 1'b1, "R8 finish strobe", 32'(pc_we), 1);
        chk(pc_vis == npc, "R6/R7 final pc", 32'(pc_vis), 32'(npc));
        chk(lr_we == lnk, "R12 link strobe", 32'(lr_we), 32'(lnk));
        if (lnk) chk(lr_data == cpc, "R12 link value", 32'(lr_data), 32'(cpc));
        @(negedge clk);
        commit_start = 0; pkt_start = 0; enq_valid = 0;
        chk(!busy && !pc_we && pc_vis == npc, "R8 after finish",
            32'(pc_vis), 32'(npc));
        last_pc_exp = npc;
        mn = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk(!busy && !overflow && !rf_we && !pc_we && !lr_we && pc_vis == '0,
            "R1 reset outputs", {busy, overflow, rf_we, pc_we, lr_we}, 0);
        rst_n = 1;
        @(negedge clk);

        // R6 first branch wins, fn-pc kind counts, R12 link
        do_pkt(16'h1000);
        do_enq(2'd0, 5'd3, 16'h0033, 16'h0100, 0);
        do_enq(2'd2, 5'd0, 16'h2000, 16'h0104, 0);
        do_enq(2'd1, 5'd0, 16'h3000, 16'h0108, 0);
        do_enq(2'd3, 5'd7, 16'h0077, 16'h0108, 0);
        do_commit(16'h1010, 1, 0, 0, 0, 0, 0);

        // R7 no branch, R9 filtered branch does not count, R11 force
        do_pkt(16'h1010);
        do_enq(2'd1, 5'd0, 16'h4000, 16'h0200, 0);
        do_enq(2'd0, 5'd1, 16'h0011, 16'h0200, 1);
        do_enq(2'd0, 5'd2, 16'h0022, 16'h0204, 0);
        do_commit(16'h1020, 0, 1, 16'h0200, 0, 0, 0);

        // R10 fp benign vs non-benign
        do_pkt(16'h1020);
        do_enq(2'd0, 5'd4, 16'h0044, 16'h0300, 0);
        do_commit(16'h1030, 0, 1, 16'h0300, 1, 8'h05, 0);
        do_pkt(16'h1030);
        do_enq(2'd0, 5'd4, 16'h0045, 16'h0300, 0);
        do_enq(2'd1, 5'd0, 16'h5000, 16'h0300, 1);
        do_commit(16'h1040, 0, 1, 16'h0300, 1, 8'h09, 0);

        // R3 overflow drop and sticky
        do_pkt(16'h1040);
        for (int i = 0; i < DEPTH + 2; i++)
            do_enq(2'd0, IW'(i), DW'(16'h0500 + i), AW'(16'h0400 + 4 * i), 0);
        chk(overflow == 1'b1, "R3 overflow set", 32'(overflow), 1);
        do_commit(16'h1050, 0, 0, 0, 0, 0, 0);
        chk(overflow == 1'b1, "R3 overflow sticky", 32'(overflow), 1);

        // R13 inputs ignored while busy, R8 queue empty afterwards
        do_pkt(16'h1050);
        do_enq(2'd0, 5'd9, 16'h0099, 16'h0600, 0);
        do_enq(2'd0, 5'd10, 16'h00AA, 16'h0604, 0);
        do_commit(16'h1060, 0, 0, 0, 0, 0, 1);
        chk(pkt_base_pc == 16'h1050, "R13 pkt_start ignored", 32'(pkt_base_pc), 32'h1050);
        do_commit(16'h1070, 1, 0, 0, 0, 0, 0);

        // random packets
        for (int p = 0; p < 60; p++) begin
            int n;
            logic [AW-1:0] eia;
            do_pkt(AW'($urandom));
            n = $urandom_range(0, DEPTH + 2);
            for (int i = 0; i < n; i++)
                do_enq(2'($urandom_range(0, 2)), IW'($urandom),
                       DW'($urandom), AW'(16'h0100 + 4 * $urandom_range(0, 2)),
                       1'($urandom));
            chk(overflow == (n > DEPTH), "R3 random overflow", 32'(overflow),
                32'(n > DEPTH));
            eia = AW'(16'h0100 + 4 * $urandom_range(0, 2));
            case ($urandom_range(0, 4))
                0: do_commit(AW'($urandom), 1'($urandom), 1, eia, 1, 8'h01, 0);
                1: do_commit(AW'($urandom), 1'($urandom), 1, eia, 1, 8'h40, 0);
                2: do_commit(AW'($urandom), 1'($urandom), 1, eia, 0, 8'h00, 0);
                default: do_commit(AW'($urandom), 1'($urandom), 0, eia, 0, 8'h00, 0);
            endcase
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule